// File: doc/BRIEF.md
# LIN Bus and Frame Timekeeper

This block supervises bus and frame timing for a LIN slave node. It receives one tick per bit time from any time base, together with the state of the frame engine: bus asleep, transfer in progress, bus activity seen, header started, identifier decoded. From these inputs it runs three timers. The first measures how long the bus has been quiet. The second is a frame-time budget that counts down while a frame is on the bus. The third limits how long the node waits after it sends a wake-up request. When a timer crosses its limit, the block raises a sticky time-out flag. Each flag stays set until the host clears it.

The frame budget is loaded with the header allowance when a header begins. Once the frame engine knows the response length, it extends the budget by an amount that depends on that length. The host reads the three flags and the timer values. It clears each flag on its own through a clear mask.

Top module: `lin_timekeeper`

## Requirements
- R1: After reset, the idle time, frame budget and wake time are zero, all three flags are clear and no wake wait is pending.
- R2: When the bus is neither sleeping nor in a transfer, each bit tick raises the idle time by one. In a cycle without a tick, the idle time does not change.
- R3: When a tick brings the idle time to IDLE_LIMIT (25000 by default), the bus time-out flag sets. The idle time then stays at IDLE_LIMIT under further ticks.
- R4: A bus_activity pulse sets the idle time to zero, even in a cycle with a tick. It also ends a pending wake wait, and the wake time keeps its value.
- R5: While bus_sleep is high, neither the idle time nor the frame budget changes on ticks. The frame budget also holds when xfer_active is low.
- R6: hdr_start loads the frame budget with HDR_LIMIT (49 by default). A tick in the same cycle is ignored.
- R7: id_done adds round((10*resp_len + 11) * 1.4) = ((10*resp_len + 11)*14 + 5)/10 to the frame budget, saturating at 255. A tick in the same cycle is ignored. For example, a 2-byte response adds 43.
- R8: While a transfer is active and the bus is awake, each tick lowers the frame budget by one. The frame time-out flag sets on the tick at which the budget becomes zero, or on a tick while it is already zero. The budget never goes below zero.
- R9: wake_req starts a wake wait with the wake time at zero. Each tick during the wait raises the wake time. The tick that brings it to WAKE_LIMIT (128 by default) sets the wake time-out flag and ends the wait.
- R10: The flags are sticky. flag_clr bit 0 clears the bus flag, bit 1 the frame flag and bit 2 the wake flag. A set event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One pulse per bit time |
| bus_sleep | input | 1 | Bus is in sleep state |
| xfer_active | input | 1 | Frame transfer in progress |
| bus_activity | input | 1 | Bus activity seen this cycle |
| hdr_start | input | 1 | Header begins; load header allowance |
| id_done | input | 1 | Identifier decoded; extend budget |
| resp_len | input | 4 | Response data bytes for the extension |
| wake_req | input | 1 | This node sent a wake-up request |
| flag_clr | input | 3 | Per-flag clear: bus, frame, wake |
| idle_time | output | 16 | Bus idle time in bit times |
| frame_budget | output | 8 | Remaining frame budget in bit times |
| wake_time | output | 8 | Bit times since the wake request |
| wake_pending | output | 1 | Wake wait in progress |
| bus_tmo | output | 1 | Sticky bus time-out flag |
| frame_tmo | output | 1 | Sticky frame time-out flag |
| wake_tmo | output | 1 | Sticky wake time-out flag |

## Verification
The frame budget is swept over every response length from 0 to 15. Each run loads the header, extends the budget, then ticks down to the exact expiry tick. This confirms the rounding of the extension and that the flag sets on the tick that reaches zero rather than one tick early or late. The idle timer is driven to one tick short of its limit and then across it, which separates a correct threshold from an off-by-one one and also checks saturation. Further patterns are ticks during sleep, ticks with no transfer, and activity or a clear in the same cycle as a tick or a set event. These show that the priorities between competing inputs resolve as the requirements state.

// File: rtl/lin_tk_pkg.sv
package lin_tk_pkg;

    localparam int unsigned FLAG_N     = 3;
    localparam int unsigned FLAG_BUS   = 0;
    localparam int unsigned FLAG_FRAME = 1;
    localparam int unsigned FLAG_WAKE  = 2;

    // Budget extension in bit times for a response of nbytes data bytes:
    // (data + checksum bytes, 10 bits each, plus one) scaled by 1.4, rounded.
    function automatic int unsigned frame_ext(input int unsigned nbytes);
        return ((nbytes * 10 + 11) * 14 + 5) / 10;
    endfunction

endpackage

// File: rtl/lin_idle_timer.sv
module lin_idle_timer #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LIMIT = 25000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             activity,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } idle_st_t;

    idle_st_t st_d, st_q;
    logic     hit_d;

    always_comb begin
        st_d  = st_q;
        hit_d = 1'b0;
        if (activity) begin
            st_d.cnt = '0;
        end else if (run && tick && (st_q.cnt != LIM_V)) begin
            st_d.cnt = st_q.cnt + 1'b1;
            hit_d    = (st_d.cnt == LIM_V);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign hit   = hit_d;
endmodule

// File: rtl/lin_frame_budget.sv
module lin_frame_budget #(
    parameter int unsigned BUD_W     = 8,
    parameter int unsigned LEN_W     = 4,
    parameter int unsigned HDR_LIMIT = 49
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic             extend,
    input  logic [LEN_W-1:0] len,
    output logic [BUD_W-1:0] budget,
    output logic             expire
);
    import lin_tk_pkg::*;

    localparam int unsigned BUD_MAX = (1 << BUD_W) - 1;

    typedef struct packed {
        logic [BUD_W-1:0] bud;
    } bud_st_t;

    bud_st_t     st_d, st_q;
    logic        exp_d;
    int unsigned sum;

    always_comb begin
        st_d  = st_q;
        exp_d = 1'b0;
        sum   = 32'(st_q.bud) + frame_ext(32'(len));
        if (load) begin
            st_d.bud = BUD_W'(HDR_LIMIT);
        end else if (extend) begin
            st_d.bud = (sum > BUD_MAX) ? BUD_W'(BUD_MAX) : BUD_W'(sum);
        end else if (run && tick) begin
            if (st_q.bud != '0) st_d.bud = st_q.bud - 1'b1;
            exp_d = (st_d.bud == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign budget = st_q.bud;
    assign expire = exp_d;
endmodule

// File: rtl/lin_wake_wait.sv
module lin_wake_wait #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned LIMIT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             cancel,
    output logic [CNT_W-1:0] count,
    output logic             pending,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } wake_st_t;

    wake_st_t st_d, st_q;
    logic     exp_d;

    always_comb begin
        st_d  = st_q;
        exp_d = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (cancel) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy && tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == LIM_V) begin
                st_d.busy = 1'b0;
                exp_d     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign pending = st_q.busy;
    assign expire  = exp_d;
endmodule

// File: rtl/lin_tmo_flags.sv
module lin_tmo_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flg_d, flg_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            if (set[i])      flg_d[i] = 1'b1;
            else if (clr[i]) flg_d[i] = 1'b0;
            else             flg_d[i] = flg_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;
endmodule

// File: rtl/lin_timekeeper.sv
module lin_timekeeper #(
    parameter int unsigned IDLE_W     = 16,
    parameter int unsigned IDLE_LIMIT = 25000,
    parameter int unsigned FRAME_W    = 8,
    parameter int unsigned HDR_LIMIT  = 49,
    parameter int unsigned LEN_W      = 4,
    parameter int unsigned WAKE_W     = 8,
    parameter int unsigned WAKE_LIMIT = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               bus_sleep,
    input  logic               xfer_active,
    input  logic               bus_activity,
    input  logic               hdr_start,
    input  logic               id_done,
    input  logic [LEN_W-1:0]   resp_len,
    input  logic               wake_req,
    input  logic [2:0]         flag_clr,
    output logic [IDLE_W-1:0]  idle_time,
    output logic [FRAME_W-1:0] frame_budget,
    output logic [WAKE_W-1:0]  wake_time,
    output logic               wake_pending,
    output logic               bus_tmo,
    output logic               frame_tmo,
    output logic               wake_tmo
);
    import lin_tk_pkg::*;

    logic               idle_run, frame_run;
    logic               idle_hit, frame_exp, wake_exp;
    logic [FLAG_N-1:0]  flag_set, flag_q;

    assign idle_run  = !bus_sleep && !xfer_active;
    assign frame_run = xfer_active && !bus_sleep;

    lin_idle_timer #(.CNT_W(IDLE_W), .LIMIT(IDLE_LIMIT)) idle_i (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .run(idle_run),
        .activity(bus_activity), .count(idle_time), .hit(idle_hit)
    );

    lin_frame_budget #(.BUD_W(FRAME_W), .LEN_W(LEN_W), .HDR_LIMIT(HDR_LIMIT)) frame_i (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .run(frame_run),
        .load(hdr_start), .extend(id_done), .len(resp_len),
        .budget(frame_budget), .expire(frame_exp)
    );

    lin_wake_wait #(.CNT_W(WAKE_W), .LIMIT(WAKE_LIMIT)) wake_i (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .start(wake_req),
        .cancel(bus_activity), .count(wake_time), .pending(wake_pending),
        .expire(wake_exp)
    );

    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_BUS]   = idle_hit;
        flag_set[FLAG_FRAME] = frame_exp;
        flag_set[FLAG_WAKE]  = wake_exp;
    end

    lin_tmo_flags #(.N(FLAG_N)) flags_i (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(flag_q)
    );

    assign bus_tmo   = flag_q[FLAG_BUS];
    assign frame_tmo = flag_q[FLAG_FRAME];
    assign wake_tmo  = flag_q[FLAG_WAKE];
endmodule

// File: rtl/lin_timekeeper_chk.sv
module lin_timekeeper_chk #(
    parameter int unsigned IDLE_W     = 16,
    parameter int unsigned IDLE_LIMIT = 25000,
    parameter int unsigned FRAME_W    = 8,
    parameter int unsigned HDR_LIMIT  = 49,
    parameter int unsigned WAKE_W     = 8,
    parameter int unsigned WAKE_LIMIT = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_tick,
    input logic               bus_sleep,
    input logic               xfer_active,
    input logic               bus_activity,
    input logic               hdr_start,
    input logic               id_done,
    input logic               wake_req,
    input logic [2:0]         flag_clr,
    input logic [IDLE_W-1:0]  idle_time,
    input logic [FRAME_W-1:0] frame_budget,
    input logic [WAKE_W-1:0]  wake_time,
    input logic               wake_pending,
    input logic               bus_tmo,
    input logic               frame_tmo,
    input logic               wake_tmo
);
    p_idle_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(idle_time) <= IDLE_LIMIT);

    p_bus_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_tmo) |-> 32'(idle_time) == IDLE_LIMIT);

    p_activity_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_activity |=> idle_time == '0);

    p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sleep && !bus_activity) |=> $stable(idle_time));

    p_hdr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_start |=> 32'(frame_budget) == HDR_LIMIT);

    p_frame_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_tmo) |-> frame_budget == '0);

    p_wake_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_tmo) |-> (!wake_pending && 32'(wake_time) == WAKE_LIMIT));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tmo && !flag_clr[0]) |=> bus_tmo);
endmodule

bind lin_timekeeper lin_timekeeper_chk #(
    .IDLE_W(IDLE_W), .IDLE_LIMIT(IDLE_LIMIT), .FRAME_W(FRAME_W),
    .HDR_LIMIT(HDR_LIMIT), .WAKE_W(WAKE_W), .WAKE_LIMIT(WAKE_LIMIT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_sleep(bus_sleep),
    .xfer_active(xfer_active), .bus_activity(bus_activity), .hdr_start(hdr_start),
    .id_done(id_done), .wake_req(wake_req), .flag_clr(flag_clr),
    .idle_time(idle_time), .frame_budget(frame_budget), .wake_time(wake_time),
    .wake_pending(wake_pending), .bus_tmo(bus_tmo), .frame_tmo(frame_tmo),
    .wake_tmo(wake_tmo)
);

// File: tb/lin_timekeeper_tb.sv
module lin_timekeeper_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0, bus_sleep = 1'b0, xfer_active = 1'b0;
    logic        bus_activity = 1'b0, hdr_start = 1'b0, id_done = 1'b0, wake_req = 1'b0;
    logic [3:0]  resp_len = '0;
    logic [2:0]  flag_clr = '0;
    logic [15:0] idle_time;
    logic [7:0]  frame_budget, wake_time;
    logic        wake_pending, bus_tmo, frame_tmo, wake_tmo;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_timekeeper dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_sleep(bus_sleep),
        .xfer_active(xfer_active), .bus_activity(bus_activity), .hdr_start(hdr_start),
        .id_done(id_done), .resp_len(resp_len), .wake_req(wake_req), .flag_clr(flag_clr),
        .idle_time(idle_time), .frame_budget(frame_budget), .wake_time(wake_time),
        .wake_pending(wake_pending), .bus_tmo(bus_tmo), .frame_tmo(frame_tmo),
        .wake_tmo(wake_tmo)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        @(negedge clk) bit_tick = 1'b1;
        for (int i = 1; i < n; i++) @(negedge clk);
        @(negedge clk) bit_tick = 1'b0;
    endtask

    // n cycles with tick high; ends at a negedge with tick low
    task automatic tickn(input int n);
        if (n > 0) begin
            bit_tick = 1'b1;
            for (int i = 0; i < n; i++) @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    function automatic int ext_of(input int len);
        return ((10 * len + 11) * 14 + 5) / 10;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int exp_b;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 idle", idle_time, 0);
        check("R1 budget", frame_budget, 0);
        check("R1 wake", wake_time, 0);
        check("R1 flags", {bus_tmo, frame_tmo, wake_tmo, wake_pending}, 0);

        // R2 idle counting
        tickn(10);
        check("R2 idle after 10", idle_time, 10);
        repeat (3) @(negedge clk);
        check("R2 idle no tick", idle_time, 10);

        // R5 sleep holds idle
        bus_sleep = 1'b1;
        tickn(5);
        check("R5 idle in sleep", idle_time, 10);
        bus_sleep = 1'b0;

        // R4 activity wins over tick
        bus_activity = 1'b1;
        tickn(1);
        bus_activity = 1'b0;
        check("R4 idle cleared", idle_time, 0);
        tickn(7);
        check("R4 idle restart", idle_time, 7);

        // R3 bus time-out threshold
        bus_activity = 1'b1; @(negedge clk); bus_activity = 1'b0;
        tickn(24999);
        check("R3 idle before limit", idle_time, 24999);
        check("R3 no flag before limit", bus_tmo, 0);
        tickn(1);
        check("R3 idle at limit", idle_time, 25000);
        check("R3 flag at limit", bus_tmo, 1);
        tickn(3);
        check("R3 idle saturates", idle_time, 25000);
        check("R10 flag sticky", bus_tmo, 1);
        flag_clr = 3'b001; @(negedge clk); flag_clr = 3'b000;
        check("R10 bus clear", bus_tmo, 0);

        // R6 R7 R8 sweep over response lengths
        xfer_active = 1'b1;
        for (int len = 0; len < 16; len++) begin
            hdr_start = 1'b1; bit_tick = 1'b1;
            @(negedge clk);
            hdr_start = 1'b0; bit_tick = 1'b0;
            check("R6 header load", frame_budget, 49);
            id_done = 1'b1; resp_len = 4'(len); bit_tick = 1'b1;
            @(negedge clk);
            id_done = 1'b0; bit_tick = 1'b0;
            exp_b = 49 + ext_of(len);
            if (exp_b > 255) exp_b = 255;
            check("R7 extension", frame_budget, exp_b);
            tickn(exp_b - 1);
            check("R8 budget one left", frame_budget, 1);
            check("R8 no early flag", frame_tmo, 0);
            tickn(1);
            check("R8 budget zero", frame_budget, 0);
            check("R8 flag on zero", frame_tmo, 1);
            tickn(2);
            check("R8 stays zero", frame_budget, 0);
            flag_clr = 3'b010; @(negedge clk); flag_clr = 3'b000;
            check("R10 frame clear", frame_tmo, 0);
        end

        // R7 two-byte example and saturation
        hdr_start = 1'b1; @(negedge clk); hdr_start = 1'b0;
        id_done = 1'b1; resp_len = 4'd2; @(negedge clk); id_done = 1'b0;
        check("R7 two bytes", frame_budget, 92);
        id_done = 1'b1; resp_len = 4'd15; @(negedge clk);
        @(negedge clk); id_done = 1'b0;
        check("R7 saturation", frame_budget, 255);

        // R5 frame budget holds in sleep and without transfer
        hdr_start = 1'b1; @(negedge clk); hdr_start = 1'b0;
        bus_sleep = 1'b1;
        tickn(5);
        check("R5 budget in sleep", frame_budget, 49);
        bus_sleep = 1'b0; xfer_active = 1'b0;
        tickn(4);
        check("R5 budget idle bus", frame_budget, 49);

        // R9 wake wait
        bus_sleep = 1'b1;
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        check("R9 wait started", {wake_pending, wake_time}, 256);
        tickn(127);
        check("R9 wake before limit", wake_time, 127);
        check("R9 no early flag", wake_tmo, 0);
        tickn(1);
        check("R9 wake flag", wake_tmo, 1);
        check("R9 wait ended", wake_pending, 0);
        check("R9 wake at limit", wake_time, 128);
        tickn(3);
        check("R9 no count after end", wake_time, 128);
        flag_clr = 3'b100; @(negedge clk); flag_clr = 3'b000;
        check("R10 wake clear", wake_tmo, 0);

        // R4 activity ends wake wait
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        tickn(20);
        bus_activity = 1'b1; @(negedge clk); bus_activity = 1'b0;
        check("R4 wait cancelled", wake_pending, 0);
        check("R4 wake time held", wake_time, 20);
        tickn(5);
        check("R4 no flag after cancel", wake_tmo, 0);

        // R10 set wins over clear in the same cycle
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        tickn(127);
        flag_clr = 3'b100;
        tickn(1);
        flag_clr = 3'b000;
        check("R10 set beats clear", wake_tmo, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule